// File: doc/BRIEF.md
# Batched Pruned Fully-Connected Engine

This block computes a fully connected neural network layer over a small batch of input vectors held on chip. Before a layer runs, activations for every batch entry are written into per-entry buffers. A start pulse then captures the layer shape: the number of inputs per vector and the number of output neurons. Weights arrive as a stream ordered by neuron. Within a neuron they are ordered by input index. Each weight is taken once and applied to all batch entries in parallel before the next weight is requested.

Operands are 10-bit signed fixed point, so each product is 20 bits wide and can be built from general logic. An activation whose magnitude falls below a programmable threshold is pruned. For that input it issues no multiply-accumulate, but its index still advances, so later inputs stay paired with the right weights.

Each lane keeps a signed saturating accumulator. It clears at the start of every neuron. After the last input, the results leave in batch order on a valid/ready stream, tagged with the neuron and batch index. An optional leaky rectifier can be applied to each result on the way out. A done flag marks the end of the layer.

Top module: `fc_batch_engine`

## Requirements
- R1: A start pulse seen while idle captures input count, output count, threshold, rectifier enable and slope. A start pulse while a layer runs is ignored, and so are any later changes on the configuration inputs; the results still follow the captured values.
- R2: `w_ready` is low in reset and while idle. It is high while the engine waits for a weight, and low for at least the cycle after each accepted weight. Exactly one weight is consumed per handshake.
- R3: For weights streamed as neuron 0 inputs 0..N-1, then neuron 1, and so on, the result for neuron o and batch entry b is the sum over k of w[o][k]*a[b][k]. All values are signed two's complement.
- R4: An activation with |a| below the threshold contributes nothing. An activation with |a| equal to the threshold contributes. Pruned inputs keep the pairing of later inputs with their weights.
- R5: The accumulator saturates at the most positive and most negative ACC_W-bit signed values and does not wrap.
- R6: Every neuron's accumulation starts from zero; nothing carries over from the previous neuron or layer.
- R7: Results are delivered neuron by neuron in ascending order and, within a neuron, batch entry 0 to BATCH-1. Each result carries its neuron index on `res_neuron` and batch index on `res_batch`.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and both tags hold unchanged.
- R9: With the rectifier disabled the raw sum is output. With it enabled, a sum x > 0 passes unchanged. Otherwise the output is floor(x*s/128), with s the 8-bit signed slope in Q1.7, saturated to ACC_W bits.
- R10: `done` rises in the cycle after the final result of the layer is accepted, stays high while idle and clears after the next accepted start. Out of reset, `res_valid` and `done` are low.
- R11: A write with `act_we` high stores `act_data` as activation `act_idx` of batch entry `act_batch`, for use by the next layer run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a layer (taken only when idle) |
| cfg_n_in | input | IN_CNT_W | Inputs per vector, 1..IN_MAX |
| cfg_n_out | input | OUT_CNT_W | Output neurons, at least 1 |
| cfg_thresh | input | DATA_W | Unsigned pruning magnitude threshold |
| cfg_relu_en | input | 1 | Enable leaky rectifier on results |
| cfg_slope | input | SLOPE_W | Signed Q1.7 negative slope |
| act_we | input | 1 | Activation buffer write strobe |
| act_batch | input | BATCH_IDX_W | Batch entry to write |
| act_idx | input | IN_IDX_W | Input index to write |
| act_data | input | DATA_W | Signed activation value |
| w_valid | input | 1 | Weight stream valid |
| w_ready | output | 1 | Weight stream ready |
| w_data | input | DATA_W | Signed weight value |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | ACC_W | Signed result |
| res_neuron | output | OUT_CNT_W | Neuron index tag |
| res_batch | output | BATCH_IDX_W | Batch index tag |
| done | output | 1 | Layer complete flag |

## Verification
A stale accumulator, a weight paired with the wrong input index or a misjudged pruning comparison corrupts the next result emitted for that neuron. The damage is therefore visible at most one neuron's worth of weights later, and the bench compares every result against an arithmetic model. A miscounted input or neuron index shows up at once as a wrong tag or a wrong number of results before `done`. A broken handshake is caught within one cycle: either `w_ready` stays high after an accept, or held results change under backpressure.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MAC   = 2'd2,
    ST_EMIT  = 2'd3
  } fcb_state_e;
endpackage

// File: rtl/fcb_act_bank.sv
module fcb_act_bank #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 256,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  // Simple dual-port store, registered read: maps onto block RAM.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcb_mac_lane.sv
module fcb_mac_lane #(
  parameter int DATA_W = 10,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     mac_en,
  input  logic signed [DATA_W-1:0] act,
  input  logic signed [DATA_W-1:0] wgt,
  input  logic        [DATA_W-1:0] thresh,
  output logic signed [ACC_W-1:0]  acc
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int EXT_W  = ACC_W + 1 - PROD_W;
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [DATA_W:0]          mag;
  logic                     keep;
  logic signed [DATA_W-1:0] op_a;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W:0]           sum;
  logic                     ovf;

  always_comb begin
    if (act[DATA_W-1]) mag = {1'b0, ~act} + (DATA_W+1)'(1);
    else               mag = {1'b0, act};
    keep = (mag >= {1'b0, thresh});
    // Operand isolation: a pruned activation never reaches the multiplier.
    op_a = keep ? act : '0;
    prod = op_a * wgt;
    sum  = {acc[ACC_W-1], acc} + {{EXT_W{prod[PROD_W-1]}}, prod};
    ovf  = sum[ACC_W] ^ sum[ACC_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (mac_en && keep) begin
      if (ovf) acc <= sum[ACC_W] ? ACC_MIN : ACC_MAX;
      else     acc <= sum[ACC_W-1:0];
    end
  end

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0)); // R6

  AST_PRUNE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !clr && !keep) |=> $stable(acc)); // R4

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !clr && keep && !prod[PROD_W-1]) |=> (acc >= $past(acc))); // R5

  AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !clr && keep && prod[PROD_W-1]) |=> (acc <= $past(acc))); // R5
endmodule

// File: rtl/fcb_leaky.sv
module fcb_leaky #(
  parameter int ACC_W   = 32,
  parameter int SLOPE_W = 8
) (
  input  logic                      en,
  input  logic signed [SLOPE_W-1:0] slope,
  input  logic signed [ACC_W-1:0]   x,
  output logic signed [ACC_W-1:0]   y
);
  localparam int PW   = ACC_W + SLOPE_W;
  localparam int FRAC = SLOPE_W - 1;
  localparam logic [ACC_W-1:0] Y_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] Y_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shr;
  logic                 fits;

  always_comb begin
    prod = x * slope;
    shr  = prod >>> FRAC;  // arithmetic shift: rounds toward minus infinity
    fits = (shr[PW-1:ACC_W-1] == {(PW-ACC_W+1){shr[ACC_W-1]}});
    if (!en || x > 0) y = x;
    else if (fits)    y = shr[ACC_W-1:0];
    else              y = shr[PW-1] ? Y_MIN : Y_MAX;
  end
endmodule

// File: rtl/fc_batch_engine.sv
module fc_batch_engine
  import fcb_pkg::*;
#(
  parameter int BATCH     = 4,
  parameter int DATA_W    = 10,
  parameter int ACC_W     = 32,
  parameter int IN_MAX    = 256,
  parameter int OUT_CNT_W = 12,
  parameter int SLOPE_W   = 8,
  localparam int IN_IDX_W    = (IN_MAX > 1) ? $clog2(IN_MAX) : 1,
  localparam int IN_CNT_W    = $clog2(IN_MAX + 1),
  localparam int BATCH_IDX_W = (BATCH > 1) ? $clog2(BATCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [IN_CNT_W-1:0]    cfg_n_in,
  input  logic [OUT_CNT_W-1:0]   cfg_n_out,
  input  logic [DATA_W-1:0]      cfg_thresh,
  input  logic                   cfg_relu_en,
  input  logic [SLOPE_W-1:0]     cfg_slope,
  input  logic                   act_we,
  input  logic [BATCH_IDX_W-1:0] act_batch,
  input  logic [IN_IDX_W-1:0]    act_idx,
  input  logic [DATA_W-1:0]      act_data,
  input  logic                   w_valid,
  output logic                   w_ready,
  input  logic [DATA_W-1:0]      w_data,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [ACC_W-1:0]       res_data,
  output logic [OUT_CNT_W-1:0]   res_neuron,
  output logic [BATCH_IDX_W-1:0] res_batch,
  output logic                   done
);
  localparam logic [BATCH_IDX_W-1:0] B_LAST = BATCH_IDX_W'(BATCH - 1);

  fcb_state_e state, state_d;

  logic [IN_CNT_W-1:0]    n_in_q;
  logic [OUT_CNT_W-1:0]   n_out_q;
  logic [DATA_W-1:0]      thresh_q;
  logic                   relu_q;
  logic [SLOPE_W-1:0]     slope_q;
  logic [IN_IDX_W-1:0]    i_q;
  logic [OUT_CNT_W-1:0]   o_q;
  logic [BATCH_IDX_W-1:0] b_ptr;
  logic [DATA_W-1:0]      w_q;

  logic w_take, last_in, last_out, last_b, final_take, clr_lanes, mac_en;
  logic [IN_CNT_W-1:0] i_ext;

  logic [DATA_W-1:0]       act_rd  [BATCH];
  logic signed [ACC_W-1:0] acc_all [BATCH];
  logic signed [ACC_W-1:0] acc_sel;
  logic signed [ACC_W-1:0] leak_out;

  always_comb begin
    i_ext      = IN_CNT_W'(i_q);
    w_take     = w_valid && w_ready;
    last_in    = (i_ext == n_in_q - IN_CNT_W'(1));
    last_out   = (o_q == n_out_q - OUT_CNT_W'(1));
    last_b     = (b_ptr == B_LAST);
    final_take = (state == ST_EMIT) && res_valid && res_ready && last_b;
    clr_lanes  = ((state == ST_IDLE) && start) || final_take;
    mac_en     = (state == ST_MAC);
    acc_sel    = acc_all[b_ptr];
  end

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (start)  state_d = ST_FETCH;
      ST_FETCH: if (w_take) state_d = ST_MAC;
      ST_MAC:   state_d = last_in ? ST_EMIT : ST_FETCH;
      ST_EMIT:  if (final_take) state_d = last_out ? ST_IDLE : ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  // One buffer and one multiply-accumulate lane per batch entry.
  for (genvar g = 0; g < BATCH; g++) begin : g_lane
    fcb_act_bank #(
      .DATA_W(DATA_W), .DEPTH(IN_MAX), .AW(IN_IDX_W)
    ) u_bank (
      .clk   (clk),
      .we    (act_we && (act_batch == BATCH_IDX_W'(g))),
      .waddr (act_idx),
      .wdata (act_data),
      .raddr (i_q),
      .rdata (act_rd[g])
    );

    fcb_mac_lane #(
      .DATA_W(DATA_W), .ACC_W(ACC_W)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_lanes),
      .mac_en (mac_en),
      .act    (act_rd[g]),
      .wgt    (w_q),
      .thresh (thresh_q),
      .acc    (acc_all[g])
    );
  end

  fcb_leaky #(
    .ACC_W(ACC_W), .SLOPE_W(SLOPE_W)
  ) u_leaky (
    .en    (relu_q),
    .slope (slope_q),
    .x     (acc_sel),
    .y     (leak_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      n_in_q     <= '0;
      n_out_q    <= '0;
      thresh_q   <= '0;
      relu_q     <= 1'b0;
      slope_q    <= '0;
      i_q        <= '0;
      o_q        <= '0;
      b_ptr      <= '0;
      w_q        <= '0;
      w_ready    <= 1'b0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_neuron <= '0;
      res_batch  <= '0;
      done       <= 1'b0;
    end else begin
      state   <= state_d;
      w_ready <= (state_d == ST_FETCH);
      case (state)
        ST_IDLE: begin
          if (start) begin
            n_in_q   <= cfg_n_in;
            n_out_q  <= cfg_n_out;
            thresh_q <= cfg_thresh;
            relu_q   <= cfg_relu_en;
            slope_q  <= cfg_slope;
            i_q      <= '0;
            o_q      <= '0;
            b_ptr    <= '0;
            done     <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (w_take) w_q <= w_data;
        end
        ST_MAC: begin
          i_q <= last_in ? '0 : i_q + IN_IDX_W'(1);
        end
        ST_EMIT: begin
          if (!res_valid) begin
            res_valid  <= 1'b1;
            res_data   <= leak_out;
            res_neuron <= o_q;
            res_batch  <= b_ptr;
          end else if (res_ready) begin
            res_valid <= 1'b0;
            if (last_b) begin
              b_ptr <= '0;
              if (last_out) done <= 1'b1;
              else          o_q  <= o_q + OUT_CNT_W'(1);
            end else begin
              b_ptr <= b_ptr + BATCH_IDX_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (w_valid && w_ready) |=> !w_ready); // R2

  AST_NO_READY_EMIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EMIT || state == ST_IDLE) |-> !w_ready); // R2

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)
      && $stable(res_neuron) && $stable(res_batch))); // R8

  AST_BATCH_TAG: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_batch <= B_LAST)); // R7

  AST_DONE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(res_valid && res_ready)); // R10

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(n_in_q) && $stable(n_out_q) && $stable(thresh_q))); // R1
endmodule

// File: tb/fc_batch_engine_test.sv
module fc_batch_engine_test;
  localparam int B      = 3;
  localparam int DW     = 10;
  localparam int AW     = 24;
  localparam int INMAX  = 64;
  localparam int OCW    = 8;
  localparam int ICW    = 7;
  localparam int IIW    = 6;
  localparam int BIW    = 2;
  localparam longint AMAX = (longint'(1) <<< (AW - 1)) - 1;
  localparam longint AMIN = -(longint'(1) <<< (AW - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ICW-1:0] cfg_n_in = '0;
  logic [OCW-1:0] cfg_n_out = '0;
  logic [DW-1:0]  cfg_thresh = '0;
  logic           cfg_relu_en = 1'b0;
  logic [7:0]     cfg_slope = '0;
  logic           act_we = 1'b0;
  logic [BIW-1:0] act_batch = '0;
  logic [IIW-1:0] act_idx = '0;
  logic [DW-1:0]  act_data = '0;
  logic           w_valid = 1'b0;
  logic           w_ready;
  logic [DW-1:0]  w_data = '0;
  logic           res_valid;
  logic           res_ready = 1'b0;
  logic [AW-1:0]  res_data;
  logic [OCW-1:0] res_neuron;
  logic [BIW-1:0] res_batch;
  logic           done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  fc_batch_engine #(
    .BATCH(B), .DATA_W(DW), .ACC_W(AW), .IN_MAX(INMAX), .OUT_CNT_W(OCW), .SLOPE_W(8)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .cfg_n_in(cfg_n_in), .cfg_n_out(cfg_n_out),
    .cfg_thresh(cfg_thresh), .cfg_relu_en(cfg_relu_en), .cfg_slope(cfg_slope),
    .act_we(act_we), .act_batch(act_batch), .act_idx(act_idx), .act_data(act_data),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_neuron(res_neuron), .res_batch(res_batch), .done(done)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint actv, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, actv, expv, $time);
    end
  endtask

  function automatic int a_of(int b, int k, int pat, int th);
    int s;
    case (pat)
      1: begin
        s = (k + b) % 4;
        if (s == 0)      return th;
        else if (s == 1) return th - 1;
        else if (s == 2) return -th;
        else             return -(th - 1);
      end
      2: begin
        if (b == 0)      return 511;
        else if (b == 1) return -512;
        else             return (k % 2 == 1) ? 5 : -5;
      end
      3: return ((k + b) % 2 == 1) ? -512 : 511;
      default: return ((b * 37 + k * 53 + 7) % 1024) - 512;
    endcase
  endfunction

  function automatic int w_of(int o, int k, int pat);
    if (pat == 2) return (o == 0) ? 511 : -512;
    return ((o * 29 + k * 71 + 3) % 1024) - 512;
  endfunction

  function automatic longint clamp(longint v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  function automatic longint exp_of(int o, int b, int nin, int th, int relu, int slope, int pat);
    longint acc = 0;
    longint p;
    for (int k = 0; k < nin; k++) begin
      int a = a_of(b, k, pat, th);
      int m = (a < 0) ? -a : a;
      if (m >= th) acc = clamp(acc + longint'(a) * longint'(w_of(o, k, pat)));
    end
    if (relu != 0 && acc <= 0) begin
      p = acc * longint'(slope);
      acc = clamp(p >>> 7);
    end
    return acc;
  endfunction

  task automatic feeder(int nin, int nout, int pat, bit busy);
    int p = 0;
    for (int o = 0; o < nout; o++) begin
      for (int k = 0; k < nin; k++) begin
        if (p % 5 == 4) begin
          w_valid = 1'b0;
          @(negedge clk);
        end
        w_valid = 1'b1;
        w_data  = DW'(w_of(o, k, pat));
        if (busy && p == 2) begin
          start = 1'b1;  // R1: must be ignored mid-layer
          cfg_n_in = ICW'(2);
          cfg_n_out = OCW'(1);
        end
        while (!w_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(w_ready == 1'b0, "R2 ready low after accept", longint'(w_ready), 0);
        p++;
      end
    end
    w_valid = 1'b0;
  endtask

  task automatic consumer(int nin, int nout, int th, int relu, int slope, int pat, bit bp);
    for (int o = 0; o < nout; o++) begin
      for (int b = 0; b < B; b++) begin
        bit got = 0;
        bit hold = 0;
        logic [AW-1:0] hd = '0;
        while (!got) begin
          @(negedge clk);
          if (hold) begin
            chk(res_valid && res_data == hd, "R8 held result", longint'($signed(res_data)),
                longint'($signed(hd)));
            hold = 0;
          end
          res_ready = bp ? ((cyc % 3) == 2) : 1'b1;
          if (res_valid) begin
            if (res_ready) begin
              longint e = exp_of(o, b, nin, th, relu, slope, pat);
              chk(longint'($signed(res_data)) == e, "R3/R4/R5/R9 result value",
                  longint'($signed(res_data)), e);
              chk(res_neuron == OCW'(o) && res_batch == BIW'(b), "R7 tags",
                  longint'(res_neuron) * 10 + longint'(res_batch), longint'(o) * 10 + longint'(b));
              if (o == nout - 1 && b == B - 1)
                chk(done == 1'b0, "R10 done low before final accept", longint'(done), 0);
              got = 1;
            end else begin
              hold = 1;
              hd = res_data;
            end
          end
        end
      end
    end
    @(negedge clk);
    res_ready = 1'b0;
    chk(done == 1'b1, "R10 done after final accept", longint'(done), 1);
  endtask

  task automatic run_cfg(int nin, int nout, int th, int relu, int slope, int pat, bit bp, bit busy);
    // R11: load the activation buffers through the write port
    for (int b = 0; b < B; b++) begin
      for (int k = 0; k < nin; k++) begin
        @(negedge clk);
        act_we = 1'b1;
        act_batch = BIW'(b);
        act_idx = IIW'(k);
        act_data = DW'(a_of(b, k, pat, th));
      end
    end
    @(negedge clk);
    act_we = 1'b0;
    cfg_n_in = ICW'(nin);
    cfg_n_out = OCW'(nout);
    cfg_thresh = DW'(th);
    cfg_relu_en = (relu != 0);
    cfg_slope = 8'(slope);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: scramble configuration after capture
    cfg_n_in = ICW'(2);
    cfg_n_out = OCW'(1);
    cfg_thresh = DW'(1000);
    cfg_relu_en = (relu == 0);
    cfg_slope = 8'(5);
    chk(done == 1'b0, "R10 done cleared by start", longint'(done), 0);
    chk(w_ready == 1'b1, "R2 ready while waiting for weight", longint'(w_ready), 1);
    fork
      feeder(nin, nout, pat, busy);
      consumer(nin, nout, th, relu, slope, pat, bp);
    join
    @(negedge clk);
    chk(w_ready == 1'b0, "R2 ready low when idle", longint'(w_ready), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(w_ready == 1'b0, "R2 reset ready", longint'(w_ready), 0);
    chk(res_valid == 1'b0, "R10 reset valid", longint'(res_valid), 0);
    chk(done == 1'b0, "R10 reset done", longint'(done), 0);

    run_cfg(5, 4, 0, 0, 0, 0, 0, 0);      // R3 plain sums
    run_cfg(7, 3, 0, 0, 0, 0, 1, 1);      // R1 busy start, R8 backpressure
    run_cfg(8, 2, 200, 0, 0, 1, 0, 0);    // R4 threshold boundary
    run_cfg(1, 3, 512, 0, 0, 3, 0, 0);    // R4 maximum magnitude only
    run_cfg(6, 3, 0, 1, 32, 0, 1, 0);     // R9 quarter slope
    run_cfg(4, 2, 0, 1, -128, 0, 0, 0);   // R9 slope of minus one
    run_cfg(3, 2, 150, 1, 77, 0, 0, 0);   // R4 and R9 together
    run_cfg(40, 2, 0, 0, 0, 2, 0, 0);     // R5 saturation, R6 clear per neuron
    run_cfg(64, 2, 0, 1, 100, 0, 1, 0);   // full depth

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule